// File: doc/BRIEF.md
# SPI Port with Master Conflict Detection

This block is an eight-bit serial peripheral interface port that acts as either a bus master or a bus slave. A control bit selects the role. As master it produces the serial clock, shifts a byte out while shifting one in, and can drive the select line low for the length of each byte. As slave it follows an external clock and shifts only while its select input is low. When it is not selected it releases its data output and ignores the clock.

While acting as master, the port can watch its select line for another master on the same wires. When fault detection is on and the select line is an input, a low level on that line ends the transfer. The port releases its clock and data drivers in the same cycle, steps down to slave, and latches a fault flag that can raise an interrupt. The flag and the driver lock both persist until software takes the steps given below.

Software uses a four-word register bus: control, status, data and clock divisor. Every pin has a separate output value and output enable, so the pad ring can place the tri-state buffers.

Top module: `spi_mf_port`

## Requirements
- R1: Register offsets are 0 control, 1 status, 2 data and 3 divisor, and all reset to zero. Control bits are: bit0 master enable, bit1 fault detect enable, bit2 select-output enable, bit3 clock phase, bit4 interrupt enable. Status bit0 is transfer done and status bit1 is the mode fault.
- R2: When the port is master and both fault detect enable and select-output enable are set, ssOe is 1. ssOut is then 0 from the clock edge that accepts a data write until the transfer ends, and 1 while idle.
- R3: Suppose the port is master, fault detect is on and select-output enable is off. If ssIn is low, sckOe and mosiOe are 0 within two system clocks. misoOe then stays 0, even when the port is a selected slave, until control is written with master enable set.
- R4: A mode fault clears control bit0, sets status bit1 and stops the clock at low. irq is 1 while interrupt enable is set and the fault flag is set.
- R5: The fault flag clears only on a control write that follows a status read made while the flag was set. A control write with no such read leaves the flag set.
- R6: SCK idles low. After a data write in master mode, the first SCK rise comes divisor+1 system clocks after the clock edge that accepted the write. Each half period is divisor+1 clocks.
- R7: In master mode, a transfer moves eight bits MSB first in both directions, in phase 0 and in phase 1. After it ends, the data register reads the byte taken from misoIn.
- R8: A slave whose ssIn is high holds misoOe at 0. Its SCK edges set no done flag and do not disturb the byte loaded for sending.
- R9: When ssIn goes low on a slave, misoOe becomes 1 within three system clocks, and misoOut shows the MSB of the loaded byte before any SCK edge.
- R10: In slave mode, with phase 0 (sample on the rising edge) or phase 1 (sample on the falling edge), the port sends its loaded byte and receives eight bits MSB first. Status bit0 sets after the eighth sample.
- R11: Reading the data register clears the done flag. irq equals interrupt enable AND (done OR fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (read side effects) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| sckIn | input | 1 | Serial clock from pad (slave) |
| sckOut | output | 1 | Serial clock driven as master |
| sckOe | output | 1 | Serial clock driver enable |
| mosiIn | input | 1 | Master-out data from pad (slave) |
| mosiOut | output | 1 | Master-out data driven as master |
| mosiOe | output | 1 | Master-out driver enable |
| misoIn | input | 1 | Slave-out data from pad (master) |
| misoOut | output | 1 | Slave-out data driven as slave |
| misoOe | output | 1 | Slave-out driver enable |
| ssIn | input | 1 | Select line from pad |
| ssOut | output | 1 | Select line driven as master |
| ssOe | output | 1 | Select line driver enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that sckIn, ssIn and mosiIn are slow next to the system clock: each level lasts several clocks, so the two-flop synchronizer never misses an edge. They also assume a slave stays selected for the whole byte and no data write lands during an active master transfer. The stimulus drives slave clocks with eight-clock half periods and keeps ssIn low from before the first edge until after the last. It issues each master data write only after polling shows the previous transfer done. Random bytes, phases and divisors are mixed with directed cases: conflicts during a transfer, the fault-clear order, and a deselected slave.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  // Strobes from the control sequencer to the shift datapath
  typedef struct packed {
    logic loadTx;
    logic mSample;
    logic mShift;
    logic mFinish;
  } spiStrobe_t;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              ssLowSync,
  input  logic              xferDone,
  output spiStrobe_t        stb,
  output logic              isMaster,
  output logic              phaseSel,
  output logic              lockOut,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              ssOut,
  output logic              ssOe,
  output logic              irq
);
  localparam int EDGE_TOTAL = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGE_TOTAL + 1);

  logic masterEn, faultEn, ssOutEn, intEn;
  logic [DIV_W-1:0] divReg, halfCnt;
  logic [EDGE_W-1:0] edgeIdx, edgeNext;
  logic busy, sckReg, doneFlag, modfFlag, statusSeen, lockReg;
  logic wrCtrl, wrDataR, wrDiv, rdStat, rdDataR;
  logic faultNow, tick, lastEdge, oddEdge, startXfer;

  assign wrCtrl  = regWr && (regAddr == ADDR_CTRL);
  assign wrDataR = regWr && (regAddr == ADDR_DATA);
  assign wrDiv   = regWr && (regAddr == ADDR_DIV);
  assign rdStat  = regRd && (regAddr == ADDR_STAT);
  assign rdDataR = regRd && (regAddr == ADDR_DATA);

  assign faultNow  = masterEn && faultEn && !ssOutEn && ssLowSync;
  assign tick      = busy && masterEn && (halfCnt == divReg);
  assign edgeNext  = edgeIdx + 1'b1;
  assign oddEdge   = edgeNext[0];
  assign lastEdge  = (edgeNext == EDGE_W'(EDGE_TOTAL));
  assign startXfer = wrDataR && masterEn && !busy && !faultNow;

  always_comb begin
    stb = '0;
    stb.loadTx = wrDataR && !(masterEn && busy);
    if (tick && !faultNow) begin
      if (lastEdge) begin
        stb.mFinish = 1'b1;
      end else if (oddEdge) begin
        if (!phaseSel) stb.mSample = 1'b1;
        else if (edgeIdx != '0) stb.mShift = 1'b1;
      end else begin
        if (!phaseSel) stb.mShift = 1'b1;
        else stb.mSample = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterEn <= 1'b0; faultEn <= 1'b0; ssOutEn <= 1'b0;
      phaseSel <= 1'b0; intEn <= 1'b0;
      divReg <= '0; halfCnt <= '0; edgeIdx <= '0;
      busy <= 1'b0; sckReg <= 1'b0; doneFlag <= 1'b0;
      modfFlag <= 1'b0; statusSeen <= 1'b0; lockReg <= 1'b0;
    end else begin
      if (rdStat && modfFlag) statusSeen <= 1'b1;
      if (wrCtrl) begin
        masterEn <= regWrData[0];
        faultEn  <= regWrData[1];
        ssOutEn  <= regWrData[2];
        phaseSel <= regWrData[3];
        intEn    <= regWrData[4];
        if (statusSeen && modfFlag) modfFlag <= 1'b0;
        statusSeen <= 1'b0;
        if (regWrData[0]) lockReg <= 1'b0;
      end
      if (wrDiv) divReg <= DIV_W'(regWrData);

      if (xferDone) doneFlag <= 1'b1;
      else if (rdDataR || wrDataR) doneFlag <= 1'b0;

      if (busy) begin
        if (!masterEn) begin
          busy <= 1'b0;
          sckReg <= 1'b0;
        end else if (tick) begin
          halfCnt <= '0;
          edgeIdx <= edgeNext;
          sckReg <= ~sckReg;
          if (lastEdge) busy <= 1'b0;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end else if (startXfer) begin
        busy <= 1'b1;
        halfCnt <= '0;
        edgeIdx <= '0;
        sckReg <= 1'b0;
      end

      if (faultNow) begin
        masterEn <= 1'b0;
        modfFlag <= 1'b1;
        lockReg <= 1'b1;
        busy <= 1'b0;
        sckReg <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = {{(DATA_W-5){1'b0}}, intEn, phaseSel, ssOutEn, faultEn, masterEn};
      ADDR_STAT: regRdData = {{(DATA_W-2){1'b0}}, modfFlag, doneFlag};
      ADDR_DATA: regRdData = rxByte;
      default:   regRdData = DATA_W'(divReg);
    endcase
  end

  assign isMaster = masterEn;
  assign lockOut  = lockReg;
  assign sckOut   = sckReg;
  assign sckOe    = masterEn && !faultNow;
  assign mosiOe   = masterEn && !faultNow;
  assign ssOe     = masterEn && faultEn && ssOutEn;
  assign ssOut    = !busy;
  assign irq      = intEn && (doneFlag || modfFlag);

  // R4: a detected conflict leaves the port a slave with the flag raised
  assert_fault_clears_master_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> (!masterEn && modfFlag && !sckReg));

  // R5: the fault flag survives any cycle without a control write
  assert_modf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modfFlag && !wrCtrl) |=> modfFlag);

  // R6: the lead-in half period keeps SCK low
  assert_lead_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && edgeIdx == '0) |-> !sckReg);

  // R3: when the flag first appears the drivers are already released
  assert_drivers_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modfFlag) |-> (!sckOe && !mosiOe));
endmodule

// File: rtl/spi_mf_dpath.sv
module spi_mf_dpath
  import spi_mf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              ssIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic [DATA_W-1:0] wrData,
  input  spiStrobe_t        stb,
  input  logic              isMaster,
  input  logic              phaseSel,
  input  logic              lockOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              xferDone,
  output logic              ssLowSync,
  output logic              mosiOut,
  output logic              misoOut,
  output logic              misoOe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int MSB = DATA_W - 1;

  logic sckS, ssS, mosiS, sckPrev, rise, fall, slaveSel;
  logic sampBit, firstEdge;
  logic [CNT_W-1:0] bitCnt;
  logic [DATA_W-1:0] shiftReg, txHold, finByte, slvByte;

  spi_mf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) uSync (
    .clk(clk), .rstN(rstN),
    .d({sckIn, ssIn, mosiIn}),
    .q({sckS, ssS, mosiS})
  );

  assign rise      = sckS && !sckPrev;
  assign fall      = !sckS && sckPrev;
  assign slaveSel  = !isMaster && !ssS;
  assign ssLowSync = !ssS;
  assign finByte   = {shiftReg[MSB-1:0], (phaseSel ? misoIn : sampBit)};
  assign slvByte   = {shiftReg[MSB-1:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0; sampBit <= 1'b0; firstEdge <= 1'b1;
      bitCnt <= '0; shiftReg <= '0; txHold <= '0; rxByte <= '0;
      xferDone <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      sckPrev <= sckS;
      if (stb.loadTx) txHold <= wrData;
      if (isMaster) begin
        bitCnt <= '0;
        firstEdge <= 1'b1;
        if (stb.loadTx) shiftReg <= wrData;
        if (stb.mSample) sampBit <= misoIn;
        if (stb.mShift) shiftReg <= {shiftReg[MSB-1:0], sampBit};
        if (stb.mFinish) begin
          shiftReg <= finByte;
          rxByte <= finByte;
          xferDone <= 1'b1;
        end
      end else if (!slaveSel) begin
        shiftReg <= stb.loadTx ? wrData : txHold;
        bitCnt <= '0;
        firstEdge <= 1'b1;
      end else if (!phaseSel) begin
        if (rise) begin
          sampBit <= mosiS;
          if (bitCnt == CNT_W'(DATA_W-1)) begin
            shiftReg <= slvByte;
            rxByte <= slvByte;
            xferDone <= 1'b1;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else if (fall && bitCnt != '0) begin
          shiftReg <= {shiftReg[MSB-1:0], sampBit};
        end
      end else begin
        if (rise) begin
          firstEdge <= 1'b0;
          if (!firstEdge) shiftReg <= {shiftReg[MSB-1:0], sampBit};
        end else if (fall) begin
          sampBit <= mosiS;
          if (bitCnt == CNT_W'(DATA_W-1)) begin
            shiftReg <= slvByte;
            rxByte <= slvByte;
            xferDone <= 1'b1;
            bitCnt <= '0;
            firstEdge <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

  assign mosiOut = shiftReg[MSB];
  assign misoOut = shiftReg[MSB];
  assign misoOe  = slaveSel && !lockOut;

  // R8: a deselected slave holds no partial count and reports nothing
  assert_deselect_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && ssS) |=> (bitCnt == '0 && !xferDone));

  // R10: the sample counter never passes the byte length
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(DATA_W));

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);
endmodule

// File: rtl/spi_mf_port.sv
module spi_mf_port
  import spi_mf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssIn,
  output logic              ssOut,
  output logic              ssOe,
  output logic              irq
);
  spiStrobe_t stb;
  logic isMaster, phaseSel, lockOut, ssLowSync, xferDone;
  logic [DATA_W-1:0] rxByte;

  spi_mf_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData),
    .rxByte(rxByte), .ssLowSync(ssLowSync), .xferDone(xferDone),
    .stb(stb), .isMaster(isMaster), .phaseSel(phaseSel), .lockOut(lockOut),
    .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe),
    .ssOut(ssOut), .ssOe(ssOe), .irq(irq)
  );

  spi_mf_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk(clk), .rstN(rstN),
    .sckIn(sckIn), .ssIn(ssIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .wrData(regWrData), .stb(stb),
    .isMaster(isMaster), .phaseSel(phaseSel), .lockOut(lockOut),
    .rxByte(rxByte), .xferDone(xferDone), .ssLowSync(ssLowSync),
    .mosiOut(mosiOut), .misoOut(misoOut), .misoOe(misoOe)
  );
endmodule

// File: tb/tb_spi_mf_port.sv
module tb_spi_mf_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssIn = 1'b1, misoIn;
  logic sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe, ssOut, ssOe, irq;

  int checks = 0;
  int failures = 0;

  // bench-side slave model used when the port is master
  logic bsOn = 1'b0, bsCph = 1'b0, bsSckPrev = 1'b0, bsMosiPrev = 1'b0;
  logic [7:0] bsTx = '0, bsRx = '0;
  int bsEdges = 0;

  assign misoIn = bsTx[7];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mf_port dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe),
    .ssIn(ssIn), .ssOut(ssOut), .ssOe(ssOe), .irq(irq)
  );

  always @(negedge clk) begin
    if (bsOn && sckOut != bsSckPrev) begin
      if (sckOut) begin
        if (!bsCph) bsRx = {bsRx[6:0], bsMosiPrev};
        else if (bsEdges != 0) bsTx = {bsTx[6:0], 1'b0};
      end else begin
        if (!bsCph) bsTx = {bsTx[6:0], 1'b0};
        else bsRx = {bsRx[6:0], bsMosiPrev};
      end
      bsEdges++;
    end
    bsSckPrev = sckOut;
    bsMosiPrev = mosiOut;
  end

  function automatic logic [7:0] expCtrl(logic m, logic f, logic s, logic c, logic i);
    return {3'b000, i, c, s, f, m};
  endfunction

  function automatic logic expIrq(logic ie, logic dn, logic mf);
    return ie && (dn || mf);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic masterXfer(logic [7:0] tx, logic [7:0] stx, logic cph, logic [7:0] dv);
    logic [7:0] r;
    bsTx = stx; bsRx = '0; bsEdges = 0; bsCph = cph; bsOn = 1'b1;
    wrReg(2'd3, dv);
    wrReg(2'd0, expCtrl(1'b1, 1'b1, 1'b1, cph, 1'b0));
    chk("R2 ssOe with select output", ssOe, 1'b1);
    chk("R2 ssOut idle high", ssOut, 1'b1);
    wrReg(2'd2, tx);
    chk("R2 ssOut low in transfer", ssOut, 1'b0);
    waitClk(16 * (int'(dv) + 1) + 4);
    chk("R2 ssOut high after", ssOut, 1'b1);
    chk("R6 sck idle low", sckOut, 1'b0);
    rdReg(2'd1, r);
    chk("R7 master done flag", r, 8'h01);
    rdReg(2'd2, r);
    chk("R7 master received byte", r, stx);
    chk("R7 remote received byte", bsRx, tx);
    bsOn = 1'b0;
  endtask

  task automatic slaveXfer(logic [7:0] m, logic [7:0] stx, logic cph, logic ie);
    logic [7:0] got, r;
    got = '0;
    wrReg(2'd0, expCtrl(1'b0, 1'b0, 1'b0, cph, ie));
    wrReg(2'd2, stx);
    ssIn = 1'b0;
    waitClk(3);
    chk("R9 misoOe on select", misoOe, 1'b1);
    chk("R9 first bit before clock", misoOut, stx[7]);
    waitClk(3);
    for (int i = 7; i >= 0; i--) begin
      if (!cph) begin
        mosiIn = m[i];
        waitClk(HALF);
        got[i] = misoOut;
        sckIn = 1'b1;
        waitClk(HALF);
        sckIn = 1'b0;
      end else begin
        sckIn = 1'b1;
        mosiIn = m[i];
        waitClk(HALF);
        got[i] = misoOut;
        sckIn = 1'b0;
        waitClk(HALF);
      end
    end
    waitClk(6);
    chk("R11 irq after slave byte", irq, expIrq(ie, 1'b1, 1'b0));
    ssIn = 1'b1;
    waitClk(3);
    rdReg(2'd1, r);
    chk("R10 slave done flag", r, 8'h01);
    rdReg(2'd2, r);
    chk("R10 slave received byte", r, m);
    chk("R10 slave sent byte", got, stx);
    rdReg(2'd1, r);
    chk("R11 done cleared by data read", r, 8'h00);
    chk("R11 irq cleared", irq, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd7331));
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);

    // R1 reset state
    rdReg(2'd0, r); chk("R1 ctrl reset", r, 8'h00);
    rdReg(2'd1, r); chk("R1 status reset", r, 8'h00);
    rdReg(2'd3, r); chk("R1 divisor reset", r, 8'h00);
    chk("R1 sckOe reset", sckOe, 1'b0);
    chk("R1 misoOe reset", misoOe, 1'b0);
    chk("R1 ssOe reset", ssOe, 1'b0);
    chk("R1 irq reset", irq, 1'b0);
    wrReg(2'd0, expCtrl(1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    rdReg(2'd0, r); chk("R1 ctrl readback", r, 8'h1D);
    wrReg(2'd0, 8'h00);

    // R6 first SCK rise after divisor+1 clocks
    bsTx = 8'h3C; bsRx = '0; bsEdges = 0; bsCph = 1'b0; bsOn = 1'b1;
    wrReg(2'd3, 8'd3);
    wrReg(2'd0, expCtrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wrReg(2'd2, 8'hC3);
    waitClk(3);
    chk("R6 sck low during lead", sckOut, 1'b0);
    waitClk(1);
    chk("R6 sck rises at divisor+1", sckOut, 1'b1);
    waitClk(4);
    chk("R6 half period of divisor+1", sckOut, 1'b0);
    waitClk(70);
    rdReg(2'd2, r); chk("R7 directed byte", r, 8'h3C);
    chk("R7 directed remote byte", bsRx, 8'hC3);
    bsOn = 1'b0;

    // R7 random master transfers, both phases
    for (int n = 0; n < 10; n++) begin
      masterXfer(8'($urandom), 8'($urandom), 1'($urandom), 8'($urandom % 4));
    end

    // R8 deselected slave ignores SCK
    wrReg(2'd0, expCtrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wrReg(2'd2, 8'hA5);
    for (int i = 0; i < 8; i++) begin
      mosiIn = 1'b1; sckIn = 1'b1; waitClk(HALF);
      sckIn = 1'b0; waitClk(HALF);
      chk("R8 misoOe off while deselected", misoOe, 1'b0);
    end
    rdReg(2'd1, r); chk("R8 no done while deselected", r, 8'h00);
    slaveXfer(8'h5A, 8'hA5, 1'b0, 1'b1);

    // R10 slave transfers, directed and random
    slaveXfer(8'h81, 8'h7E, 1'b1, 1'b1);
    for (int n = 0; n < 10; n++) begin
      slaveXfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    end

    // R3 R4 R5 conflict during a master transfer
    bsTx = 8'h00; bsOn = 1'b0;
    wrReg(2'd3, 8'd3);
    wrReg(2'd0, expCtrl(1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
    chk("R2 no select drive without enable", ssOe, 1'b0);
    wrReg(2'd2, 8'hF0);
    waitClk(10);
    ssIn = 1'b0;
    waitClk(2);
    chk("R3 sckOe released", sckOe, 1'b0);
    chk("R3 mosiOe released", mosiOe, 1'b0);
    waitClk(2);
    chk("R4 sck stopped low", sckOut, 1'b0);
    chk("R4 irq on fault", irq, expIrq(1'b1, 1'b0, 1'b1));
    rdReg(2'd0, r); chk("R4 master bit cleared", r, expCtrl(1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
    wrReg(2'd0, expCtrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    waitClk(3);
    chk("R5 flag kept without status read", irq, 1'b1);
    chk("R3 misoOe locked while selected", misoOe, 1'b0);
    rdReg(2'd1, r); chk("R4 fault flag set", r, 8'h02);
    wrReg(2'd0, expCtrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    rdReg(2'd1, r); chk("R5 flag cleared by read then write", r, 8'h00);
    chk("R5 irq cleared", irq, 1'b0);
    ssIn = 1'b1;
    waitClk(3);
    wrReg(2'd0, expCtrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R3 drivers back with master", sckOe, 1'b1);
    wrReg(2'd0, 8'h00);
    ssIn = 1'b0;
    waitClk(3);
    chk("R3 lock released after master set", misoOe, 1'b1);
    ssIn = 1'b1;
    waitClk(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule